// File: doc/BRIEF.md
# Queued Asynchronous Serial Transmitter

This block drives one asynchronous serial line from a single-entry holding register and a shift register. Software-side logic writes a character into the holding register. The character moves to the shifter at the next character boundary, and the holding register is then free for the next write. The block consumes a bit-rate tick from outside, and every bit on the line lasts exactly one tick period.

Besides data characters, the shifter can carry two kinds of control character that are queued like data. A break is an all-zero character whose length depends on the long-break select and the 9-bit mode. An idle character is all ones, one full character long, and it is queued on every rising edge of the enable input. A send-break input that is held high re-queues a break each time one loads. Dropping the enable input does not give up the line at once. The pin-ownership output stays high until the character in flight and any queued break or idle character have gone out.

Top module: `utxq_tx`

## Requirements
- R1: After reset the line is 1, the holding-empty flag is 1, the complete flag is 1, and with enable low the ownership output is 0.
- R2: In 8-bit mode a data character is sent as a 0 start bit, eight data bits least significant bit first, and a 1 stop bit. The character is 10 bits, and each bit is held for exactly one tick period.
- R3: In 9-bit mode the ninth-bit input, sampled when the character loads into the shifter, is sent after data bit 7 and before the stop bit. The character is 11 bits.
- R4: A data write clears the holding-empty flag and the complete flag in the following cycle. The holding-empty flag sets again on the tick that moves the byte into the shifter, and that tick starts the start bit.
- R5: When a character ends and nothing is queued, the complete flag sets on that tick and the line stays at 1.
- R6: A rising edge on send-break while enabled queues one break character, which is all zeros with no 1 stop bit.
- R7: The break length in bit times is 10 with long select 0 and 8-bit mode, 11 with long select 0 and 9-bit mode, 13 with long select 1 and 8-bit mode, and 14 with long select 1 and 9-bit mode.
- R8: If send-break is still 1 on the tick that loads a break, a second break is queued and follows directly.
- R9: Each 0-to-1 transition of enable queues one idle character of all ones that lasts one character length (10 or 11 bits). The complete flag stays 0 while it is sent.
- R10: At each character boundary at most one item loads, in this order: a queued break, then a queued idle, then pending data.
- R11: With enable low, the character in flight and any queued break or idle still go out, and ownership stays 1 until they finish. Ownership then drops to 0, and data written while disabled is not sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character data to send |
| ninth_bit | input | 1 | Extra data bit for 9-bit mode |
| tx_enable | input | 1 | Transmitter enable; a rising edge queues an idle character |
| brk_req | input | 1 | Send-break request |
| brk_long | input | 1 | Selects the long break |
| mode9 | input | 1 | Selects 9-bit characters |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register can take a write |
| tx_done | output | 1 | Nothing left to send |
| line_own | output | 1 | Transmitter still owns the line |

## Verification
The bench builds the block with its default parameters: eight data bits and three extra bit times for the long break. With these values both character sizes (10 and 11 bits) and all four break lengths (10, 11, 13 and 14 bit times) are reachable and checked bit by bit. Ticks arrive every third clock, so the bench checks that each bit holds steady across the whole tick period. It also checks back-to-back characters, a held break request, the load order when break, idle and data all wait on the same boundary, and the drain of queued work after enable falls.

// File: rtl/utxq_pkg.sv
`timescale 1ns/1ps
package utxq_pkg;
  // what the shifter takes on at a character boundary
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_BRK  = 2'd1,
    LD_IDLE = 2'd2,
    LD_DATA = 2'd3
  } load_kind_e;
endpackage

// File: rtl/utxq_queue.sv
`timescale 1ns/1ps
// Edge detection on enable and send-break; pending break / idle flags.
module utxq_queue (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_enable,
  input  logic brk_req,
  input  logic take_brk,
  input  logic take_idle,
  output logic brk_pend,
  output logic idle_pend
);
  logic en_q, brk_q, brk_pend_q, idle_pend_q;
  logic brk_rise, en_rise, brk_pend_d, idle_pend_d;

  always_comb begin
    brk_rise    = brk_req & ~brk_q & tx_enable;
    en_rise     = tx_enable & ~en_q;
    // a break that loads while the request is still high re-arms itself
    brk_pend_d  = brk_rise | (take_brk ? (brk_req & tx_enable) : brk_pend_q);
    idle_pend_d = en_rise | (idle_pend_q & ~take_idle);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      brk_q       <= 1'b0;
      brk_pend_q  <= 1'b0;
      idle_pend_q <= 1'b0;
    end else begin
      en_q        <= tx_enable;
      brk_q       <= brk_req;
      brk_pend_q  <= brk_pend_d;
      idle_pend_q <= idle_pend_d;
    end
  end

  assign brk_pend  = brk_pend_q;
  assign idle_pend = idle_pend_q;
endmodule

// File: rtl/utxq_holding.sv
`timescale 1ns/1ps
// Single-entry holding register with empty and complete flags.
module utxq_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take_data,
  input  logic              take_any,
  input  logic              drained,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full,
  output logic              done
);
  logic [DATA_W-1:0] data_q;
  logic              full_q, done_q, full_d, done_d;

  always_comb begin
    full_d = wr_en | (full_q & ~take_data);
    if (wr_en)         done_d = 1'b0;
    else if (take_any) done_d = 1'b0;
    else if (drained)  done_d = 1'b1;
    else               done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (wr_en) begin
      data_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      done_q <= 1'b1;
    end else begin
      full_q <= full_d;
      done_q <= done_d;
    end
  end

  assign hold_data = data_q;
  assign hold_full = full_q;
  assign done      = done_q;
endmodule

// File: rtl/utxq_shifter.sv
`timescale 1ns/1ps
// Shift register, bit counter and boundary arbitration.
module utxq_shifter
  import utxq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LONG_EXTRA = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              brk_pend,
  input  logic              idle_pend,
  input  logic              data_rdy,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              ninth_bit,
  input  logic              mode9,
  input  logic              brk_long,
  output logic              txd,
  output logic              active,
  output load_kind_e        load_kind,
  output logic              drained
);
  localparam int BASE_LEN = DATA_W + 2;
  localparam int SH_W     = DATA_W + 3 + LONG_EXTRA;
  localparam int CNT_W    = $clog2(SH_W + 1);

  logic [SH_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, char_len, brk_len;
  logic             act_q, act_d, boundary;

  always_comb begin
    char_len = CNT_W'(BASE_LEN) + CNT_W'(mode9);
    brk_len  = char_len + (brk_long ? CNT_W'(LONG_EXTRA) : '0);
    boundary = bit_tick & (~act_q | (cnt_q == CNT_W'(1)));

    if (!boundary)      load_kind = LD_NONE;
    else if (brk_pend)  load_kind = LD_BRK;
    else if (idle_pend) load_kind = LD_IDLE;
    else if (data_rdy)  load_kind = LD_DATA;
    else                load_kind = LD_NONE;

    drained = boundary & act_q & (load_kind == LD_NONE);

    sh_d  = sh_q;
    cnt_d = cnt_q;
    act_d = act_q;
    unique case (load_kind)
      LD_BRK: begin
        sh_d  = '0;
        cnt_d = brk_len;
        act_d = 1'b1;
      end
      LD_IDLE: begin
        sh_d  = '1;
        cnt_d = char_len;
        act_d = 1'b1;
      end
      LD_DATA: begin
        sh_d             = '1;
        sh_d[0]          = 1'b0;
        sh_d[DATA_W:1]   = hold_data;
        if (mode9) sh_d[DATA_W+1] = ninth_bit;
        cnt_d = char_len;
        act_d = 1'b1;
      end
      default: begin
        if (boundary) begin
          act_d = 1'b0;
        end else if (bit_tick && act_q) begin
          sh_d  = {1'b1, sh_q[SH_W-1:1]};
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign txd    = act_q ? sh_q[0] : 1'b1;
  assign active = act_q;
endmodule

// File: rtl/utxq_tx.sv
`timescale 1ns/1ps
// Top: queued asynchronous serial transmitter.
module utxq_tx
  import utxq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LONG_EXTRA = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ninth_bit,
  input  logic              tx_enable,
  input  logic              brk_req,
  input  logic              brk_long,
  input  logic              mode9,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_done,
  output logic              line_own
);
  load_kind_e        load_kind;
  logic              brk_pend, idle_pend, active, drained;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;

  utxq_queue queue_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_enable (tx_enable),
    .brk_req   (brk_req),
    .take_brk  (load_kind == LD_BRK),
    .take_idle (load_kind == LD_IDLE),
    .brk_pend  (brk_pend),
    .idle_pend (idle_pend)
  );

  utxq_holding #(.DATA_W(DATA_W)) hold_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .take_data (load_kind == LD_DATA),
    .take_any  (load_kind != LD_NONE),
    .drained   (drained),
    .hold_data (hold_data),
    .hold_full (hold_full),
    .done      (tx_done)
  );

  utxq_shifter #(.DATA_W(DATA_W), .LONG_EXTRA(LONG_EXTRA)) shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .brk_pend  (brk_pend),
    .idle_pend (idle_pend),
    .data_rdy  (hold_full & tx_enable),
    .hold_data (hold_data),
    .ninth_bit (ninth_bit),
    .mode9     (mode9),
    .brk_long  (brk_long),
    .txd       (txd),
    .active    (active),
    .load_kind (load_kind),
    .drained   (drained)
  );

  assign hold_empty = ~hold_full;
  assign line_own   = tx_enable | active | brk_pend | idle_pend;
endmodule

// File: rtl/utxq_tx_chk.sv
`timescale 1ns/1ps
module utxq_tx_chk
  import utxq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       wr_en,
  input logic       tx_enable,
  input logic       brk_req,
  input logic       txd,
  input logic       hold_empty,
  input logic       tx_done,
  input logic       line_own,
  input logic       active,
  input logic       brk_pend,
  input logic       idle_pend,
  input load_kind_e load_kind
);
  assert_done_line_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> txd);

  assert_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!hold_empty && !tx_done));

  assert_empty_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> $past(bit_tick));

  assert_data_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_kind == LD_DATA) |-> (!brk_pend && !idle_pend));

  assert_load_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_kind != LD_NONE) |-> bit_tick);

  assert_break_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_kind == LD_BRK && brk_req && tx_enable) |=> brk_pend);

  assert_released_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_own && !tx_enable) |=> !active);
endmodule

bind utxq_tx utxq_tx_chk chk_i (.*);

// File: tb/utxq_tx_tb.sv
`timescale 1ns/1ps
module utxq_tx_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bit_tick, wr_en, ninth_bit, tx_enable, brk_req, brk_long, mode9;
  logic [DW-1:0] wr_data;
  logic          txd, hold_empty, tx_done, line_own;
  int            nchk = 0;
  int            nfail = 0;
  bit            finished = 1'b0;

  always #2.5 clk = ~clk;

  utxq_tx dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_data(wr_data), .ninth_bit(ninth_bit), .tx_enable(tx_enable),
    .brk_req(brk_req), .brk_long(brk_long), .mode9(mode9), .txd(txd),
    .hold_empty(hold_empty), .tx_done(tx_done), .line_own(line_own)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one tick period of three clocks; returns the bit shown after the tick
  task automatic do_tick(input string req, output logic v);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    v = txd;
    repeat (2) begin
      @(negedge clk);
      chk(req, "bit steady over tick period", txd, v);
    end
  endtask

  function automatic logic frame_bit(input logic [DW-1:0] d, input logic m9,
                                     input logic nb, input int i);
    if (i == 0) return 1'b0;
    if (i <= DW) return d[i-1];
    if (m9 && i == DW + 1) return nb;
    return 1'b1;
  endfunction

  task automatic expect_frame(input string req, input logic [DW-1:0] d,
                              input logic m9, input logic nb, input int first);
    logic v;
    for (int i = first; i < DW + 2 + int'(m9); i++) begin
      do_tick(req, v);
      chk(req, $sformatf("frame bit %0d", i), v, frame_bit(d, m9, nb, i));
    end
  endtask

  task automatic expect_level(input string req, input logic lvl, input int n);
    logic v;
    for (int i = 0; i < n; i++) begin
      do_tick(req, v);
      chk(req, $sformatf("level bit %0d", i), v, lvl);
    end
  endtask

  task automatic write_byte(input logic [DW-1:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_brk();
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; bit_tick = 0; wr_en = 0; wr_data = '0; ninth_bit = 0;
    tx_enable = 0; brk_req = 0; brk_long = 0; mode9 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "txd", txd, 1);
    chk("R1", "hold_empty", hold_empty, 1);
    chk("R1", "tx_done", tx_done, 1);
    chk("R1", "line_own", line_own, 0);
  endtask

  task automatic t_idle_after_enable();
    logic v;
    tx_enable = 1'b1;
    @(negedge clk);
    chk("R9", "line_own after enable", line_own, 1);
    do_tick("R9", v);
    chk("R9", "idle first bit", v, 1);
    chk("R9", "tx_done low during idle", tx_done, 0);
    expect_level("R9", 1'b1, DW + 1);
    chk("R9", "tx_done low at idle end", tx_done, 0);
    do_tick("R5", v);
    chk("R5", "line high after idle", v, 1);
    chk("R5", "tx_done after idle", tx_done, 1);
  endtask

  task automatic t_byte8(input logic [DW-1:0] d);
    logic v;
    write_byte(d);
    chk("R4", "hold_empty cleared by write", hold_empty, 0);
    chk("R4", "tx_done cleared by write", tx_done, 0);
    do_tick("R2", v);
    chk("R2", "start bit", v, 0);
    chk("R4", "hold_empty set on load tick", hold_empty, 1);
    expect_frame("R2", d, 1'b0, 1'b0, 1);
    do_tick("R5", v);
    chk("R5", "line high after stop", v, 1);
    chk("R5", "tx_done after frame", tx_done, 1);
  endtask

  task automatic t_back_to_back(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic v;
    write_byte(a);
    do_tick("R2", v);
    chk("R2", "first start bit", v, 0);
    write_byte(b);
    chk("R4", "hold full behind shifter", hold_empty, 0);
    expect_frame("R2", a, 1'b0, 1'b0, 1);
    do_tick("R4", v);
    chk("R4", "second start right after stop", v, 0);
    chk("R4", "hold_empty on second load", hold_empty, 1);
    chk("R5", "tx_done stays low between frames", tx_done, 0);
    expect_frame("R2", b, 1'b0, 1'b0, 1);
    do_tick("R5", v);
    chk("R5", "tx_done after pair", tx_done, 1);
  endtask

  task automatic t_nine(input logic [DW-1:0] d, input logic nb);
    logic v;
    mode9 = 1'b1; ninth_bit = nb;
    write_byte(d);
    do_tick("R3", v);
    chk("R3", "start bit", v, 0);
    ninth_bit = ~nb;  // later changes must not reach the line
    expect_frame("R3", d, 1'b1, nb, 1);
    do_tick("R3", v);
    chk("R3", "line high after 11 bits", v, 1);
    chk("R3", "tx_done after 11 bits", tx_done, 1);
    mode9 = 1'b0; ninth_bit = 1'b0;
  endtask

  task automatic t_break_len(input logic lng, input logic m9);
    logic v;
    int   blen;
    blen = 10 + int'(m9) + 3 * int'(lng);
    brk_long = lng; mode9 = m9;
    pulse_brk();
    do_tick("R6", v);
    chk("R6", "break first bit", v, 0);
    chk("R6", "tx_done low in break", tx_done, 0);
    expect_level("R7", 1'b0, blen - 1);
    do_tick("R7", v);
    chk("R7", $sformatf("break ends after %0d bits", blen), v, 1);
    chk("R7", "tx_done after break", tx_done, 1);
    brk_long = 1'b0; mode9 = 1'b0;
  endtask

  task automatic t_break_held();
    logic v;
    brk_req = 1'b1;
    @(negedge clk);
    do_tick("R8", v);
    chk("R8", "first break bit", v, 0);
    brk_req = 1'b0;
    expect_level("R8", 1'b0, 9);
    do_tick("R8", v);
    chk("R8", "second break follows", v, 0);
    chk("R8", "tx_done low in second break", tx_done, 0);
    expect_level("R8", 1'b0, 9);
    do_tick("R8", v);
    chk("R8", "only two breaks", v, 1);
    chk("R8", "tx_done after breaks", tx_done, 1);
  endtask

  task automatic t_priority(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic v;
    write_byte(a);
    do_tick("R10", v);
    chk("R10", "frame A start", v, 0);
    write_byte(b);
    pulse_brk();
    tx_enable = 1'b0;
    @(negedge clk);
    tx_enable = 1'b1;
    @(negedge clk);
    expect_frame("R10", a, 1'b0, 1'b0, 1);
    expect_level("R10", 1'b0, 10);   // break goes first
    chk("R10", "data still held after break", hold_empty, 0);
    expect_level("R10", 1'b1, 10);   // then the idle character
    chk("R10", "data still held after idle", hold_empty, 0);
    expect_frame("R10", b, 1'b0, 1'b0, 0);
    do_tick("R10", v);
    chk("R10", "tx_done after queue", tx_done, 1);
  endtask

  task automatic t_disable_drain(input logic [DW-1:0] c);
    logic v;
    write_byte(c);
    do_tick("R11", v);
    chk("R11", "frame start", v, 0);
    pulse_brk();
    tx_enable = 1'b0;
    @(negedge clk);
    chk("R11", "owned while frame runs", line_own, 1);
    expect_frame("R11", c, 1'b0, 1'b0, 1);
    chk("R11", "owned while break queued", line_own, 1);
    expect_level("R11", 1'b0, 10);
    chk("R11", "owned during last break bit", line_own, 1);
    do_tick("R11", v);
    chk("R11", "line high after drain", v, 1);
    chk("R11", "ownership released", line_own, 0);
    chk("R11", "tx_done after drain", tx_done, 1);
    write_byte(8'h33);
    chk("R11", "write while disabled held", hold_empty, 0);
    expect_level("R11", 1'b1, 6);
    chk("R11", "data not sent while disabled", hold_empty, 0);
    chk("R11", "still released", line_own, 0);
  endtask

  initial begin
    t_reset();
    t_idle_after_enable();
    t_byte8(8'hA5);
    t_byte8(8'h01);
    t_back_to_back(8'h0F, 8'hE2);
    t_nine(8'h3C, 1'b1);
    t_nine(8'hC3, 1'b0);
    t_break_len(1'b0, 1'b0);
    t_break_len(1'b0, 1'b1);
    t_break_len(1'b1, 1'b0);
    t_break_len(1'b1, 1'b1);
    t_break_held();
    t_priority(8'h5A, 8'hC3);
    t_disable_drain(8'h96);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule